// File: doc/BRIEF.md
# MSI Capture Interrupt Bank

This block collects message-signalled interrupts arriving at a PCIe root port and turns them into a single level interrupt for the host CPU. Software programs a 64-bit target address, a 32-bit vector enable word and a 32-bit mask word through a small 32-bit register port. Inbound memory writes are presented on a valid/ready stream carrying address, data and byte enables. A full-word write that lands exactly on the programmed address is taken as a message, and its data value is used as a vector number.

When a message's vector is enabled, the matching bit of a 32-bit pending word is set. The interrupt rises as soon as any pending bit is unmasked. Software retires pending bits by writing a value that is XORed into the pending word. The interrupt drops only when the pending word reaches zero. Masking a pending bit does not drop it.

The inbound stream never applies back-pressure: `in_ready` is held high and a message is consumed in any cycle where `in_valid` is high. A write that does not qualify is consumed and discarded.

Top module: `msi_cap_bank`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and the capture window is closed.
- R2: The target address is written and read as two 32-bit halves: offset 0x00 holds the low half and offset 0x04 holds the high half. Writing one half leaves the other half unchanged.
- R3: The enable word (offset 0x08) and the mask word (offset 0x0C) read back their stored values. Offsets with no register read zero.
- R4: A qualifying inbound write with data v (v < 32) sets pending bit v only if enable bit v is 1. Otherwise the pending word is unchanged. The pending word reads at offset 0x10.
- R5: An inbound write is ignored in any of these cases: the enable word is zero, the address differs from the programmed address, or the byte enables are not 4'b1111.
- R6: An inbound write whose data has any of bits 31:5 set is ignored.
- R7: `irq` is high in the cycle after the pending word has an unmasked bit set. This includes the case where a mask write unmasks an already pending bit.
- R8: A register write to offset 0x10 XORs the written value into the pending word.
- R9: `irq` falls only in the cycle after the pending word becomes zero. Masking a pending bit, or an XOR that leaves the word nonzero, keeps `irq` high.
- R10: When a pending-word write and a capture occur in the same cycle, the XOR is applied first and the captured bit is ORed in afterwards.
- R11: `in_ready` is always high, so no inbound write is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Inbound write accepted (always 1) |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number) |
| in_be | input | 4 | Inbound write byte enables |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
A software XOR on the pending word and an inbound capture can land in the same clock edge. The bench provokes this by driving a pending-word write and a matching message in one cycle, with the written value chosen equal to the captured bit.

With this choice, XOR-then-set leaves the bit set, while set-then-XOR would clear it. The test is judged by reading the pending word and `irq` afterwards.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned TGT_AW   = 64;
  localparam int unsigned NUM_VEC  = 32;
  localparam logic [REG_AW-1:0] OFS_TGT_LO  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_TGT_HI  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_VEC_EN  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_VEC_MSK = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_PEND    = 8'h10;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned AW  = REG_AW,
  parameter int unsigned DW  = REG_DW,
  parameter int unsigned TAW = TGT_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wen,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  pend_q,
  output logic [DW-1:0]  rdata,
  output logic [TAW-1:0] tgt_addr,
  output logic [DW-1:0]  vec_en,
  output logic [DW-1:0]  vec_msk,
  output logic [DW-1:0]  vec_msk_d,
  output logic           pend_wr
);
  localparam int unsigned HALF = TAW / 2;

  logic [HALF-1:0] tgt_lo_q, tgt_hi_q;
  logic            wr_lo, wr_hi, wr_en, wr_msk;

  assign wr_lo   = wen && (addr == OFS_TGT_LO);
  assign wr_hi   = wen && (addr == OFS_TGT_HI);
  assign wr_en   = wen && (addr == OFS_VEC_EN);
  assign wr_msk  = wen && (addr == OFS_VEC_MSK);
  assign pend_wr = wen && (addr == OFS_PEND);

  assign vec_msk_d = wr_msk ? wdata : vec_msk;
  assign tgt_addr  = {tgt_hi_q, tgt_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      vec_en   <= '0;
      vec_msk  <= '0;
    end else begin
      if (wr_lo) tgt_lo_q <= HALF'(wdata);
      if (wr_hi) tgt_hi_q <= HALF'(wdata);
      if (wr_en) vec_en   <= wdata;
      vec_msk <= vec_msk_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_TGT_LO:  rdata = DW'(tgt_lo_q);
      OFS_TGT_HI:  rdata = DW'(tgt_hi_q);
      OFS_VEC_EN:  rdata = vec_en;
      OFS_VEC_MSK: rdata = vec_msk;
      OFS_PEND:    rdata = pend_q;
      default:     rdata = '0;
    endcase
  end

  // R2
  hi_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(tgt_hi_q));
  // R2
  lo_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> $stable(tgt_lo_q));
endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match
  import msi_cap_pkg::*;
#(
  parameter int unsigned NV  = NUM_VEC,
  parameter int unsigned DW  = REG_DW,
  parameter int unsigned TAW = TGT_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [TAW-1:0] in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic [3:0]     in_be,
  input  logic [TAW-1:0] tgt_addr,
  input  logic [NV-1:0]  vec_en,
  output logic [NV-1:0]  set_vec
);
  localparam int unsigned VW = $clog2(NV);

  logic          window_open, hit;
  logic [VW-1:0] vec;

  assign window_open = |vec_en;
  assign vec         = in_data[VW-1:0];
  assign hit = in_valid && window_open && (in_addr == tgt_addr) &&
               (in_be == 4'b1111) && ((in_data >> VW) == '0);

  for (genvar i = 0; i < NV; i++) begin : g_dec
    assign set_vec[i] = hit && (vec == VW'(i)) && vec_en[i];
  end

  // R4
  set_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |-> ((set_vec & ~vec_en) == '0));
  // R5
  closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en == '0) |-> (set_vec == '0));
  // R4
  single_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: rtl/msi_cap_status.sv
module msi_cap_status
  import msi_cap_pkg::*;
#(
  parameter int unsigned NV = NUM_VEC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_wr,
  input  logic [NV-1:0] wdata,
  input  logic [NV-1:0] set_vec,
  input  logic [NV-1:0] vec_msk,
  input  logic [NV-1:0] vec_msk_d,
  output logic [NV-1:0] pend_q,
  output logic          irq_q
);
  logic [NV-1:0] pend_x, pend_d;
  logic          irq_d;

  assign pend_x = pend_wr ? (pend_q ^ wdata) : pend_q;
  assign pend_d = pend_x | set_vec;

  always_comb begin
    if (pend_d == '0)                   irq_d = 1'b0;
    else if (|(pend_d & ~vec_msk_d))    irq_d = 1'b1;
    else                                irq_d = irq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  // R7
  unmasked_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~vec_msk)) |-> irq_q);
  // R9
  fall_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> (pend_q == '0));
  // R8
  xor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && set_vec == '0) |=> (pend_q == $past(pend_q ^ wdata)));
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && set_vec == '0) |=> $stable(pend_q));
endmodule

// File: rtl/msi_cap_bank.sv
module msi_cap_bank
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TGT_AW-1:0] in_addr,
  input  logic [REG_DW-1:0] in_data,
  input  logic [3:0]        in_be,
  output logic              irq
);
  logic [TGT_AW-1:0]  tgt_addr;
  logic [REG_DW-1:0]  vec_en, vec_msk, vec_msk_d, pend_q;
  logic [NUM_VEC-1:0] set_vec;
  logic               pend_wr;

  assign in_ready = 1'b1;

  msi_cap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .pend_q(pend_q), .rdata(reg_rdata),
    .tgt_addr(tgt_addr), .vec_en(vec_en), .vec_msk(vec_msk),
    .vec_msk_d(vec_msk_d), .pend_wr(pend_wr)
  );

  msi_cap_match u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .in_be(in_be), .tgt_addr(tgt_addr),
    .vec_en(vec_en), .set_vec(set_vec)
  );

  msi_cap_status u_status (
    .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .wdata(reg_wdata),
    .set_vec(set_vec), .vec_msk(vec_msk), .vec_msk_d(vec_msk_d),
    .pend_q(pend_q), .irq_q(irq)
  );
endmodule

// File: tb/tb_msi_cap_bank.sv
module tb_msi_cap_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  always #2 clk = ~clk;

  msi_cap_bank dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1 chk(req, reg_rdata, exp);
  endtask

  task automatic msg(logic [63:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk); in_valid = 1; in_addr = a; in_data = d; in_be = be;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset();
    rd("R1", 8'h00, 0); rd("R1", 8'h04, 0); rd("R1", 8'h08, 0);
    rd("R1", 8'h0C, 0); rd("R1", 8'h10, 0);
    chk("R1", irq, 0); chk("R11", in_ready, 1);
  endtask

  task automatic t_regs();
    wr(8'h00, 32'hFEE0_0000); wr(8'h04, 32'h1);
    wr(8'h00, 32'hFEE0_1000);
    rd("R2", 8'h04, 32'h1); rd("R2", 8'h00, 32'hFEE0_1000);
    wr(8'h08, 32'h0000_00A5); wr(8'h0C, 32'h0);
    rd("R3", 8'h08, 32'hA5); wr(8'h0C, 32'h1234_5678);
    rd("R3", 8'h0C, 32'h1234_5678); rd("R3", 8'h14, 0);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_capture();
    msg(TGT, 2, 4'hF); rd("R4", 8'h10, 32'h4); chk("R7", irq, 1);
    msg(TGT, 1, 4'hF); rd("R4", 8'h10, 32'h4);
    msg(TGT, 32'h25, 4'hF); rd("R6", 8'h10, 32'h4);
    msg(TGT + 4, 0, 4'hF); rd("R5", 8'h10, 32'h4);
    msg(TGT, 0, 4'h3); rd("R5", 8'h10, 32'h4);
    wr(8'h10, 32'h4); rd("R8", 8'h10, 0); chk("R9", irq, 0);
  endtask

  task automatic t_mask();
    msg(TGT, 5, 4'hF); chk("R7", irq, 1);
    wr(8'h0C, 32'h20); chk("R9", irq, 1);
    wr(8'h10, 32'h20); chk("R9", irq, 0);
    msg(TGT, 5, 4'hF); rd("R4", 8'h10, 32'h20); chk("R7", irq, 0);
    wr(8'h0C, 32'h0); chk("R7", irq, 1);
    wr(8'h10, 32'h20); chk("R9", irq, 0);
  endtask

  task automatic t_xor_partial();
    msg(TGT, 0, 4'hF); msg(TGT, 7, 4'hF); rd("R4", 8'h10, 32'h81);
    wr(8'h10, 32'h01); rd("R8", 8'h10, 32'h80); chk("R9", irq, 1);
    wr(8'h10, 32'h80); chk("R9", irq, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    reg_wen = 1; reg_addr = 8'h10; reg_wdata = 32'h4;
    in_valid = 1; in_addr = TGT; in_data = 2; in_be = 4'hF;
    @(negedge clk); reg_wen = 0; in_valid = 0;
    rd("R10", 8'h10, 32'h4); chk("R10", irq, 1);
    wr(8'h10, 32'h4); chk("R9", irq, 0);
  endtask

  task automatic t_closed();
    wr(8'h08, 32'h0); msg(TGT, 0, 4'hF);
    rd("R5", 8'h10, 0); chk("R5", irq, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_regs(); t_capture(); t_mask();
    t_xor_partial(); t_same_cycle(); t_closed();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule